// File: doc/BRIEF.md
# High-Speed Host Command and Doorbell Register

This block holds the command, status, interrupt-enable and configure-flag registers of a high-speed USB host controller. Software reaches it over a simple word-addressed register bus with a single-cycle write strobe and a combinational read path. The block drives the schedule enables into the schedule engine. It also raises a doorbell request toward the engine, which answers with a pulse once it has dropped every cached piece of asynchronous schedule state.

That answer sets a sticky "async advanced" status flag. The block withdraws the doorbell only after the flag is set. When enabled, the flag produces an interrupt at the next threshold tick rather than at once.

A command-bit request starts a light reset. For a fixed number of cycles it returns the doorbell, the flag, the interrupt and both schedule enables to zero. It leaves the configure flag and the interrupt enable untouched, so port ownership survives.

Top module: `hs_host_cmd_regs`

## Requirements
- R1: After rst_ni is released, every register reads 0 and doorbell_o, async_en_o, periodic_en_o, cfg_flag_o, irq_o and proto_err_o are low.
- R2: A write to address 0 loads async enable from data bit 5 and periodic enable from data bit 4. The values drive async_en_o/periodic_en_o and read back at the same bits from the edge of the write onward.
- R3: Writing address 0 with bit 6 set while async enable is already 1 raises the doorbell (readable at address 0 bit 6 and on doorbell_o) from the next edge.
- R4: An evict_done_i pulse while the doorbell is pending sets the status flag (address 1 bit 5) at that edge. The doorbell falls one edge later, never before the flag is set.
- R5: Writing 1 to address 1 bit 5 clears the flag at that edge and deasserts irq_o with it. Writing 0 there has no effect.
- R6: irq_o rises at the first edge where thresh_tick_i is high while the flag is already 1 and the interrupt enable (address 2 bit 5) is 1. A tick before the flag sets does not raise it. Once high, it stays high until the flag is cleared.
- R7: Writing address 0 with bit 6 set while async enable is 0 leaves the doorbell low and pulses proto_err_o for exactly one cycle.
- R8: Writing address 0 with bit 7 set starts a light reset. Bit 7 reads 1 for exactly 8 cycles and then 0. Throughout, doorbell, flag, irq and both enables are 0 and all register writes are ignored.
- R9: Light reset leaves the configure flag (address 3 bit 0, driving cfg_flag_o) and the interrupt enable unchanged.
- R10: With the light-reset build option off (LRESET_EN = 0), address 0 bit 7 always reads 0 and a bit-7 write does not clear the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 command, 1 status, 2 interrupt enable, 3 configure flag |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| evict_done_i | input | 1 | Engine pulse: cached async state has been evicted |
| thresh_tick_i | input | 1 | Interrupt-threshold tick pulse |
| doorbell_o | output | 1 | Pending doorbell request to the engine |
| async_en_o | output | 1 | Asynchronous schedule enable |
| periodic_en_o | output | 1 | Periodic schedule enable |
| cfg_flag_o | output | 1 | Configure flag (ownership), kept across light reset |
| irq_o | output | 1 | Async-advance interrupt |
| proto_err_o | output | 1 | One-cycle pulse on a doorbell rung with async disabled |

## Verification
Each register write is visible on the outputs and at the read port one edge after the write strobe. The flag rises on the same edge as the evict pulse, and the doorbell falls one edge after that. The interrupt rises on the edge that samples a tick, and the error pulse lasts the one cycle after the offending write. Light reset shows bit 7 high for eight edges after its write. The bench drives inputs on falling edges and samples on the next falling edge, so each check lands exactly one rising edge after its stimulus. Multi-cycle checks such as the reset window and the doorbell drop step one falling edge at a time and compare at each step.

// File: rtl/hs_cmd_pkg.sv
package hs_cmd_pkg;
  typedef enum logic [1:0] {
    ADDR_CMD = 2'd0,
    ADDR_STS = 2'd1,
    ADDR_IEN = 2'd2,
    ADDR_CFG = 2'd3
  } reg_addr_e;

  localparam int unsigned BIT_LRST = 7;
  localparam int unsigned BIT_DB   = 6;
  localparam int unsigned BIT_ASE  = 5;
  localparam int unsigned BIT_PSE  = 4;
  localparam int unsigned BIT_AAF  = 5;
  localparam int unsigned BIT_CFG  = 0;
endpackage

// File: rtl/hs_cmd_lreset.sv
module hs_cmd_lreset #(
  parameter bit          ENABLE = 1'b1,
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  if (ENABLE) begin : g_on
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt_q <= '0;
      else if (req_i && cnt_q == '0) cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)          cnt_q <= cnt_q - 1'b1;
    end
    assign busy_o = (cnt_q != '0);
  end else begin : g_off
    logic unused_in;
    assign unused_in = req_i ^ clk_i ^ rst_ni;
    assign busy_o    = 1'b0;
  end
endmodule

// File: rtl/hs_cmd_doorbell.sv
module hs_cmd_doorbell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ring_i,
  input  logic evict_i,
  input  logic tick_i,
  input  logic ien_i,
  input  logic flag_w1c_i,
  output logic db_o,
  output logic flag_o,
  output logic irq_o
);
  logic db_q, posted_q, flag_q, irq_q;
  logic set_flag, flag_d;

  assign set_flag = db_q & evict_i & ~posted_q;
  assign flag_d   = set_flag | (flag_q & ~flag_w1c_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q     <= 1'b0;
      posted_q <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else if (clr_i) begin
      db_q     <= 1'b0;
      posted_q <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      // doorbell drops one edge after the flag was posted
      if (posted_q) begin
        db_q     <= 1'b0;
        posted_q <= 1'b0;
      end else if (set_flag) begin
        posted_q <= 1'b1;
      end
      if (ring_i) db_q <= 1'b1;
      flag_q <= flag_d;
      irq_q  <= flag_d & (irq_q | (tick_i & flag_q & ien_i));
    end
  end

  assign db_o   = db_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/hs_host_cmd_regs.sv
module hs_host_cmd_regs
  import hs_cmd_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter bit          LRESET_EN = 1'b1,
  parameter int unsigned LR_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              evict_done_i,
  input  logic              thresh_tick_i,
  output logic              doorbell_o,
  output logic              async_en_o,
  output logic              periodic_en_o,
  output logic              cfg_flag_o,
  output logic              irq_o,
  output logic              proto_err_o
);
  logic wr_cmd, wr_sts, wr_ien, wr_cfg;
  logic lr_req, lr_busy, lr_clr, wr_ok;
  logic ring_req, ring_ok;
  logic async_q, periodic_q, ien_async, cfg_q, perr_q;
  logic aaf_flag, db;

  assign wr_ok  = reg_wr_i & ~lr_clr;
  assign wr_cmd = reg_wr_i && reg_addr_e'(reg_addr_i) == ADDR_CMD;
  assign wr_sts = wr_ok && reg_addr_e'(reg_addr_i) == ADDR_STS;
  assign wr_ien = wr_ok && reg_addr_e'(reg_addr_i) == ADDR_IEN;
  assign wr_cfg = wr_ok && reg_addr_e'(reg_addr_i) == ADDR_CFG;

  assign lr_req   = LRESET_EN & wr_cmd & reg_wdata_i[BIT_LRST] & ~lr_busy;
  assign lr_clr   = lr_req | lr_busy;
  assign ring_req = wr_cmd & ~lr_clr & reg_wdata_i[BIT_DB];
  assign ring_ok  = ring_req & async_q;

  hs_cmd_lreset #(.ENABLE(LRESET_EN), .CYCLES(LR_CYCLES)) u_lreset (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (lr_req),
    .busy_o (lr_busy)
  );

  hs_cmd_doorbell u_doorbell (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (lr_clr),
    .ring_i     (ring_ok),
    .evict_i    (evict_done_i),
    .tick_i     (thresh_tick_i),
    .ien_i      (ien_async),
    .flag_w1c_i (wr_sts & reg_wdata_i[BIT_AAF]),
    .db_o       (db),
    .flag_o     (aaf_flag),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      async_q    <= 1'b0;
      periodic_q <= 1'b0;
      ien_async  <= 1'b0;
      cfg_q      <= 1'b0;
      perr_q     <= 1'b0;
    end else begin
      perr_q <= ring_req & ~async_q;
      if (lr_clr) begin
        async_q    <= 1'b0;
        periodic_q <= 1'b0;
      end else if (wr_cmd) begin
        async_q    <= reg_wdata_i[BIT_ASE];
        periodic_q <= reg_wdata_i[BIT_PSE];
      end
      if (wr_ien) ien_async <= reg_wdata_i[BIT_AAF];
      if (wr_cfg) cfg_q     <= reg_wdata_i[BIT_CFG];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_CMD: begin
        reg_rdata_o[BIT_LRST] = lr_busy;
        reg_rdata_o[BIT_DB]   = db;
        reg_rdata_o[BIT_ASE]  = async_q;
        reg_rdata_o[BIT_PSE]  = periodic_q;
      end
      ADDR_STS: reg_rdata_o[BIT_AAF] = aaf_flag;
      ADDR_IEN: reg_rdata_o[BIT_AAF] = ien_async;
      ADDR_CFG: reg_rdata_o[BIT_CFG] = cfg_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;

  assign doorbell_o    = db;
  assign async_en_o    = async_q;
  assign periodic_en_o = periodic_q;
  assign cfg_flag_o    = cfg_q;
  assign proto_err_o   = perr_q;
endmodule

// File: rtl/hs_host_cmd_regs_chk.sv
module hs_host_cmd_regs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic doorbell_o,
  input logic async_en_o,
  input logic periodic_en_o,
  input logic cfg_flag_o,
  input logic irq_o,
  input logic proto_err_o,
  input logic thresh_tick_i,
  input logic aaf_flag,
  input logic lr_busy,
  input logic ien_async
);
  assert_db_rise_needs_async_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(doorbell_o) |-> $past(async_en_o));

  assert_db_drop_after_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(doorbell_o) && !lr_busy |-> $past(aaf_flag));

  assert_irq_needs_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> aaf_flag);

  assert_irq_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(thresh_tick_i) && $past(aaf_flag) && $past(ien_async));

  assert_perr_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> !proto_err_o);

  assert_lreset_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_busy |-> !doorbell_o && !aaf_flag && !irq_o && !async_en_o && !periodic_en_o);

  assert_lreset_keeps_cfg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_busy && $past(lr_busy) |-> $stable(cfg_flag_o) && $stable(ien_async));
endmodule

bind hs_host_cmd_regs hs_host_cmd_regs_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .doorbell_o    (doorbell_o),
  .async_en_o    (async_en_o),
  .periodic_en_o (periodic_en_o),
  .cfg_flag_o    (cfg_flag_o),
  .irq_o         (irq_o),
  .proto_err_o   (proto_err_o),
  .thresh_tick_i (thresh_tick_i),
  .aaf_flag      (aaf_flag),
  .lr_busy       (lr_busy),
  .ien_async     (ien_async)
);

// File: tb/hs_host_cmd_regs_tb.sv
module hs_host_cmd_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_off;
  logic        evict = 1'b0, tick = 1'b0;
  logic        db, aen, pen, cfg, irq, perr;
  logic        db2, aen2, pen2, cfg2, irq2, perr2;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  hs_host_cmd_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evict_done_i(evict),
    .thresh_tick_i(tick), .doorbell_o(db), .async_en_o(aen),
    .periodic_en_o(pen), .cfg_flag_o(cfg), .irq_o(irq), .proto_err_o(perr)
  );

  hs_host_cmd_regs #(.LRESET_EN(1'b0)) u_dut_off (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_off), .evict_done_i(evict),
    .thresh_tick_i(tick), .doorbell_o(db2), .async_en_o(aen2),
    .periodic_en_o(pen2), .cfg_flag_o(cfg2), .irq_o(irq2), .proto_err_o(perr2)
  );

  function automatic logic [31:0] exp_cmd(logic busy, logic d, logic a, logic p);
    return {24'd0, busy, d, a, p, 4'd0};
  endfunction

  function automatic logic [31:0] exp_bit5(logic v);
    return {26'd0, v, 5'd0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write(logic [1:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_evict();
    evict = 1'b1; step(); evict = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    logic [31:0] seed_v;
    seed_v = $urandom(32'd11);
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r); chk("R1 reg", r, '0);
    end
    chk("R1 outs", {26'd0, db, aen, pen, cfg, irq, perr}, '0);

    // R2 random enable patterns
    for (int i = 0; i < 40; i++) begin
      logic [31:0] v;
      v = $urandom & 32'h0000_0030;
      write(2'd0, v);
      rd(2'd0, r);
      chk("R2 readback", r, exp_cmd(1'b0, 1'b0, v[5], v[4]));
      chk("R2 outs", {30'd0, aen, pen}, {30'd0, v[5], v[4]});
    end

    // R7 ring with async disabled
    write(2'd0, 32'h0000_0010);
    write(2'd0, 32'h0000_0050);
    chk("R7 perr pulse", {31'd0, perr}, 32'd1);
    chk("R7 doorbell low", {31'd0, db}, 32'd0);
    step();
    chk("R7 perr one cycle", {31'd0, perr}, 32'd0);

    // R3 ring accepted
    write(2'd2, 32'h20);
    write(2'd0, 32'h20);
    write(2'd0, 32'h60);
    rd(2'd0, r);
    chk("R3 doorbell read", r, exp_cmd(1'b0, 1'b1, 1'b1, 1'b0));
    chk("R3 perr quiet", {31'd0, perr}, 32'd0);

    // R6 tick before flag is ignored
    pulse_tick();
    chk("R6 early tick", {31'd0, irq}, 32'd0);

    // R4 evict sets flag, doorbell drops one edge later
    for (int k = 0; k < int'($urandom_range(0, 4)); k++) step();
    chk("R4 db held", {31'd0, db}, 32'd1);
    pulse_evict();
    rd(2'd1, r);
    chk("R4 flag set", r, exp_bit5(1'b1));
    chk("R4 db still up", {31'd0, db}, 32'd1);
    step();
    chk("R4 db dropped", {31'd0, db}, 32'd0);
    chk("R6 no irq without tick", {31'd0, irq}, 32'd0);

    // R6 tick raises irq, which holds
    pulse_tick();
    chk("R6 irq on tick", {31'd0, irq}, 32'd1);
    repeat (3) step();
    chk("R6 irq holds", {31'd0, irq}, 32'd1);

    // R5 W1C
    write(2'd1, 32'h0);
    rd(2'd1, r);
    chk("R5 write0 no effect", r, exp_bit5(1'b1));
    write(2'd1, 32'h20);
    rd(2'd1, r);
    chk("R5 flag cleared", r, '0);
    chk("R5 irq cleared", {31'd0, irq}, 32'd0);

    // R8/R9 light reset
    write(2'd3, 32'h1);
    write(2'd0, 32'h70);
    pulse_evict();
    write(2'd0, 32'h80);
    for (int c = 1; c <= 7; c++) begin
      rd(2'd0, r);
      chk("R8 busy window", r, exp_cmd(1'b1, 1'b0, 1'b0, 1'b0));
      chk("R8 quiet", {29'd0, irq, aen, pen}, '0);
      write(2'd3, 32'h0);
    end
    rd(2'd0, r);
    chk("R8 busy last", r, exp_cmd(1'b1, 1'b0, 1'b0, 1'b0));
    step();
    rd(2'd0, r);
    chk("R8 done", r, '0);
    rd(2'd1, r);
    chk("R8 flag zero", r, '0);
    chk("R9 cfg kept", {31'd0, cfg}, 32'd1);
    rd(2'd2, r);
    chk("R9 ien kept", r, exp_bit5(1'b1));

    // R10 build without light reset
    write(2'd0, 32'h30);
    write(2'd0, 32'hB0);
    addr = 2'd0; #1;
    chk("R10 bit7 zero", rdata_off, exp_cmd(1'b0, 1'b0, 1'b1, 1'b1));
    chk("R10 enables kept", {30'd0, aen2, pen2}, 32'd3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule